// File: doc/BRIEF.md
# Speculative Load Disambiguation Table

This block tracks loads that software has hoisted above stores whose addresses were not yet known. When such an early load issues, it records the load in a small table. The table is indexed by the load's destination register, not by its address. Each record keeps the 8-byte-aligned physical block the load touched, a mask of the bytes it read, and a valid flag.

Every later store is snooped against all records in the table. A record that shares the store's block and has at least one byte in common with it is invalidated. This byte-level test catches partial overlaps and accesses of different sizes. Later, a check names a register and asks whether its record is still valid. A miss tells the recovery logic that the load has to be issued again. A global clear drops every record at once, for example on a pipeline flush.

The table holds 32 records in 16 sets of 2 ways. The set is chosen by the low four bits of the register number, and each way stores the full register number as its tag.

Top module: `spec_ld_table`

## Requirements
- R1: After reset every record is invalid, so any check returns a miss.
- R2: An allocation for a register makes a check of that exact register hit from the next cycle on. A check of a different register that maps to the same set does not hit.
- R3: The recorded byte mask starts at byte address[2:0] of the 8-byte block given by address[39:3]. Its length is 1, 2, 4 or 8 bytes for size codes 0, 1, 2 and 3. Bytes that would fall past the end of the block are dropped.
- R4: A store whose block equals a record's block and whose byte mask intersects the record's mask invalidates that record. Store masks use the same encoding as R3.
- R5: A store in a different block, or in the same block with no common byte, leaves every record unchanged.
- R6: A single store invalidates all overlapping records, including records in different sets.
- R7: A new allocation for a register that already has a valid record replaces that record in place. The old address no longer matches, and the other way of the set is untouched.
- R8: When both ways of a set hold other registers, an allocation evicts the way that was allocated least recently. A replacement under R7 counts as an allocation.
- R9: An invalid way in the set is filled before any valid way is evicted.
- R10: A check in the same cycle as a store that invalidates that register's record returns a miss.
- R11: A clear invalidates every record. A check in the same cycle as a clear misses, and an allocation in the same cycle as a clear is dropped.
- R12: A check sees the state before any allocation made in the same cycle. A store in the same cycle as an allocation does not invalidate the new record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Record an early load this cycle |
| ld_reg | input | 7 | Destination register of the early load |
| ld_addr | input | 40 | Physical address of the early load |
| ld_size | input | 2 | Load size code (0 = 1, 1 = 2, 2 = 4, 3 = 8 bytes) |
| st_en | input | 1 | Snoop a store this cycle |
| st_addr | input | 40 | Physical address of the store |
| st_size | input | 2 | Store size code, same encoding as ld_size |
| chk_en | input | 1 | Query a register this cycle |
| chk_reg | input | 7 | Register being queried |
| chk_hit | output | 1 | Query found a valid record for chk_reg |
| inval_all | input | 1 | Invalidate all records |

## Verification
The hardest state to reach from the ports is a full set in which the replacement order matters. To get there, the stimulus allocates three and then four registers that share the same low four bits. It refreshes one of them between the allocations, and it kills a way with a store before allocating again. The eviction choice then shows up in which register still hits.

Byte-level overlap is probed with single-byte stores placed just inside, just outside and just past a truncated mask. A final directed run fills all 32 records, then confirms that a single store removes exactly one record.

// File: rtl/spec_ld_pkg.sv
package spec_ld_pkg;

    localparam int unsigned REG_W       = 7;
    localparam int unsigned PA_W        = 40;
    localparam int unsigned OFF_W       = 3;
    localparam int unsigned MASK_W      = 1 << OFF_W;
    localparam int unsigned BLK_W       = PA_W - OFF_W;
    localparam int unsigned SIZE_W      = 2;
    localparam int unsigned NUM_ENTRIES = 32;
    localparam int unsigned WAYS        = 2;
    localparam int unsigned SETS        = NUM_ENTRIES / WAYS;
    localparam int unsigned SET_W       = $clog2(SETS);
    localparam int unsigned WAY_W       = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef logic [REG_W-1:0]  reg_id_t;
    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [MASK_W-1:0] bmask_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [SET_W-1:0]  set_t;

    typedef struct packed {
        logic    vld;
        reg_id_t rid;
        blk_t    blk;
        bmask_t  bm;
    } slot_t;

    typedef struct packed {
        blk_t   blk;
        bmask_t bm;
    } footprint_t;

    // Block number and touched-byte mask of an access; bytes beyond the block are dropped.
    function automatic footprint_t footprint(logic [PA_W-1:0] addr, logic [SIZE_W-1:0] size);
        logic [2*MASK_W-1:0] span;
        footprint_t          f;
        span = '0;
        for (int b = 0; b < int'(MASK_W); b++) begin
            if (b < (32'sd1 <<< size)) span[b] = 1'b1;
        end
        span  = span << addr[OFF_W-1:0];
        f.blk = addr[PA_W-1:OFF_W];
        f.bm  = span[MASK_W-1:0];
        return f;
    endfunction

    function automatic set_t set_of(reg_id_t r);
        return r[SET_W-1:0];
    endfunction

endpackage

// File: rtl/spec_ld_snoop.sv
module spec_ld_snoop
    import spec_ld_pkg::*;
(
    input  slot_t [NUM_ENTRIES-1:0] slots,
    input  logic                    st_en,
    input  footprint_t              st_fp,
    output logic [NUM_ENTRIES-1:0]  kill
);
    // One block comparator and mask intersection per record.
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        assign kill[i] = st_en && slots[i].vld &&
                         (slots[i].blk == st_fp.blk) &&
                         (|(slots[i].bm & st_fp.bm));
    end
endmodule

// File: rtl/spec_ld_set_match.sv
module spec_ld_set_match
    import spec_ld_pkg::*;
(
    input  slot_t [WAYS-1:0] ways,
    input  reg_id_t          rid,
    output logic [WAYS-1:0]  hit
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit[w] = ways[w].vld && (ways[w].rid == rid);
    end
endmodule

// File: rtl/spec_ld_victim.sv
module spec_ld_victim
    import spec_ld_pkg::*;
(
    input  logic [WAYS-1:0] vld,
    input  logic [WAYS-1:0] hit,
    input  way_t [WAYS-1:0] age,
    output way_t            pick
);
    // Priority: same register, then first free way, then the oldest allocation.
    always_comb begin
        logic found;
        pick  = '0;
        found = 1'b0;
        for (int w = 0; w < int'(WAYS); w++) begin
            if (!found && hit[w]) begin
                pick  = way_t'(w);
                found = 1'b1;
            end
        end
        for (int w = 0; w < int'(WAYS); w++) begin
            if (!found && !vld[w]) begin
                pick  = way_t'(w);
                found = 1'b1;
            end
        end
        for (int w = 0; w < int'(WAYS); w++) begin
            if (!found && (age[w] == way_t'(WAYS - 1))) begin
                pick  = way_t'(w);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/spec_ld_table.sv
module spec_ld_table
    import spec_ld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [REG_W-1:0]  ld_reg,
    input  logic [PA_W-1:0]   ld_addr,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic              st_en,
    input  logic [PA_W-1:0]   st_addr,
    input  logic [SIZE_W-1:0] st_size,
    input  logic              chk_en,
    input  logic [REG_W-1:0]  chk_reg,
    output logic              chk_hit,
    input  logic              inval_all
);
    localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);

    slot_t [NUM_ENTRIES-1:0] tab_q, tab_d;
    way_t  [NUM_ENTRIES-1:0] age_q, age_d;

    footprint_t ld_fp, st_fp;
    assign ld_fp = footprint(ld_addr, ld_size);
    assign st_fp = footprint(st_addr, st_size);

    // Store snoop across the whole table.
    logic [NUM_ENTRIES-1:0] kill;
    spec_ld_snoop u_snoop (
        .slots (tab_q),
        .st_en (st_en),
        .st_fp (st_fp),
        .kill  (kill)
    );

    // Set slices for the query and the allocation.
    logic [IDX_W-1:0] chk_base, ld_base;
    assign chk_base = IDX_W'(set_of(chk_reg)) * IDX_W'(WAYS);
    assign ld_base  = IDX_W'(set_of(ld_reg))  * IDX_W'(WAYS);

    slot_t [WAYS-1:0] chk_ways, ld_ways;
    way_t  [WAYS-1:0] ld_ages;
    logic  [WAYS-1:0] chk_kill, ld_vld;

    always_comb begin
        for (int w = 0; w < int'(WAYS); w++) begin
            chk_ways[w] = tab_q[chk_base + IDX_W'(w)];
            chk_kill[w] = kill[chk_base + IDX_W'(w)];
            ld_ways[w]  = tab_q[ld_base + IDX_W'(w)];
            ld_ages[w]  = age_q[ld_base + IDX_W'(w)];
            ld_vld[w]   = ld_ways[w].vld;
        end
    end

    logic [WAYS-1:0] chk_match, ld_match;

    spec_ld_set_match u_chk_match (
        .ways (chk_ways),
        .rid  (chk_reg),
        .hit  (chk_match)
    );

    spec_ld_set_match u_ld_match (
        .ways (ld_ways),
        .rid  (ld_reg),
        .hit  (ld_match)
    );

    way_t ld_pick;
    spec_ld_victim u_victim (
        .vld  (ld_vld),
        .hit  (ld_match),
        .age  (ld_ages),
        .pick (ld_pick)
    );

    // Query sees the table after this cycle's store and clear, before this cycle's allocation.
    assign chk_hit = chk_en && !inval_all && (|(chk_match & ~chk_kill));

    // Next-state: store kills, then clear or allocation.
    always_comb begin
        logic [IDX_W-1:0] tgt;
        way_t             old_age;
        tab_d   = tab_q;
        age_d   = age_q;
        tgt     = ld_base + IDX_W'(ld_pick);
        old_age = age_q[tgt];
        for (int i = 0; i < int'(NUM_ENTRIES); i++) begin
            if (kill[i] || inval_all) tab_d[i].vld = 1'b0;
        end
        if (!inval_all && ld_en) begin
            tab_d[tgt].vld = 1'b1;
            tab_d[tgt].rid = ld_reg;
            tab_d[tgt].blk = ld_fp.blk;
            tab_d[tgt].bm  = ld_fp.bm;
            for (int w = 0; w < int'(WAYS); w++) begin
                if (way_t'(w) == ld_pick) begin
                    age_d[ld_base + IDX_W'(w)] = '0;
                end else if (age_q[ld_base + IDX_W'(w)] < old_age) begin
                    age_d[ld_base + IDX_W'(w)] = age_q[ld_base + IDX_W'(w)] + way_t'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tab_q <= '0;
            for (int i = 0; i < int'(NUM_ENTRIES); i++) begin
                age_q[i] <= way_t'(WAYS - 1 - (i % WAYS));
            end
        end else begin
            tab_q <= tab_d;
            age_q <= age_d;
        end
    end

endmodule

// File: rtl/spec_ld_checker.sv
module spec_ld_checker
    import spec_ld_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    ld_en,
    input logic [REG_W-1:0]        ld_reg,
    input logic [PA_W-1:0]         ld_addr,
    input logic [SIZE_W-1:0]       ld_size,
    input logic                    st_en,
    input logic [PA_W-1:0]         st_addr,
    input logic [SIZE_W-1:0]       st_size,
    input logic                    chk_en,
    input logic [REG_W-1:0]        chk_reg,
    input logic                    chk_hit,
    input logic                    inval_all,
    input slot_t [NUM_ENTRIES-1:0] tab_q
);
    logic       prev_ld;
    reg_id_t    prev_reg;
    footprint_t prev_fp, cur_st_fp;
    logic       st_overlaps_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ld  <= 1'b0;
            prev_reg <= '0;
            prev_fp  <= '0;
        end else begin
            prev_ld  <= ld_en && !inval_all;
            prev_reg <= ld_reg;
            prev_fp  <= footprint(ld_addr, ld_size);
        end
    end

    assign cur_st_fp        = footprint(st_addr, st_size);
    assign st_overlaps_prev = (cur_st_fp.blk == prev_fp.blk) && (|(cur_st_fp.bm & prev_fp.bm));

    // Duplicate register tags inside one set.
    logic [SETS-1:0] dup;
    always_comb begin
        dup = '0;
        for (int s = 0; s < int'(SETS); s++) begin
            for (int a = 0; a < int'(WAYS); a++) begin
                for (int b = a + 1; b < int'(WAYS); b++) begin
                    if (tab_q[s*WAYS+a].vld && tab_q[s*WAYS+b].vld &&
                        tab_q[s*WAYS+a].rid == tab_q[s*WAYS+b].rid) dup[s] = 1'b1;
                end
            end
        end
    end

    p_alloc_hit_r2: assert property (@(posedge clk) disable iff (rst)
        (prev_ld && chk_en && chk_reg == prev_reg && !st_en && !inval_all) |-> chk_hit);

    p_overlap_kill_r4: assert property (@(posedge clk) disable iff (rst)
        (prev_ld && chk_en && chk_reg == prev_reg && st_en && st_overlaps_prev) |-> !chk_hit);

    p_disjoint_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (prev_ld && chk_en && chk_reg == prev_reg && st_en && !st_overlaps_prev && !inval_all)
        |-> chk_hit);

    p_single_tag_r7: assert property (@(posedge clk) disable iff (rst) dup == '0);

    p_clear_empty_r11: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> !chk_hit);

endmodule

bind spec_ld_table spec_ld_checker u_chk (.*);

// File: tb/spec_ld_table_bench.sv
module spec_ld_table_bench;
    import spec_ld_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              ld_en, st_en, chk_en, inval_all;
    logic [REG_W-1:0]  ld_reg, chk_reg;
    logic [PA_W-1:0]   ld_addr, st_addr;
    logic [SIZE_W-1:0] ld_size, st_size;
    logic              chk_hit;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    spec_ld_table u_spec_ld_table (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_reg    (ld_reg),
        .ld_addr   (ld_addr),
        .ld_size   (ld_size),
        .st_en     (st_en),
        .st_addr   (st_addr),
        .st_size   (st_size),
        .chk_en    (chk_en),
        .chk_reg   (chk_reg),
        .chk_hit   (chk_hit),
        .inval_all (inval_all)
    );

    typedef struct packed {
        logic        clr;
        logic        a_v;
        logic [6:0]  a_reg;
        logic [39:0] a_addr;
        logic [1:0]  a_sz;
        logic        s_v;
        logic [39:0] s_addr;
        logic [1:0]  s_sz;
        logic        c_v;
        logic [6:0]  c_reg;
        logic        exp;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 43;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd5,  1'b0, 8'd1},  // R1
        '{1'b0, 1'b1, 7'd5,  40'h1000,  2'd2, 1'b0, 40'h0,     2'd0, 1'b1, 7'd5,  1'b0, 8'd12}, // R12
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd5,  1'b1, 8'd2},  // R2
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd21, 1'b0, 8'd2},  // R2
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b1, 40'h1004,  2'd2, 1'b1, 7'd5,  1'b1, 8'd5},  // R5
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b1, 40'h2000,  2'd3, 1'b1, 7'd5,  1'b1, 8'd5},  // R5
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd5,  1'b1, 8'd5},  // R5
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b1, 40'h1003,  2'd0, 1'b1, 7'd5,  1'b0, 8'd10}, // R10
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd5,  1'b0, 8'd4},  // R4
        '{1'b0, 1'b1, 7'd6,  40'h3006,  2'd2, 1'b0, 40'h0,     2'd0, 1'b0, 7'd0,  1'b0, 8'd3},  // R3
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b1, 40'h3008,  2'd0, 1'b1, 7'd6,  1'b1, 8'd3},  // R3
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b1, 40'h3005,  2'd0, 1'b1, 7'd6,  1'b1, 8'd3},  // R3
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b1, 40'h3007,  2'd0, 1'b1, 7'd6,  1'b0, 8'd3},  // R3
        '{1'b0, 1'b1, 7'd7,  40'h4000,  2'd3, 1'b0, 40'h0,     2'd0, 1'b0, 7'd0,  1'b0, 8'd6},  // R6
        '{1'b0, 1'b1, 7'd8,  40'h4000,  2'd0, 1'b0, 40'h0,     2'd0, 1'b0, 7'd0,  1'b0, 8'd6},  // R6
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b1, 40'h4000,  2'd1, 1'b1, 7'd7,  1'b0, 8'd6},  // R6
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd8,  1'b0, 8'd6},  // R6
        '{1'b0, 1'b1, 7'd9,  40'h5000,  2'd3, 1'b0, 40'h0,     2'd0, 1'b0, 7'd0,  1'b0, 8'd7},  // R7
        '{1'b0, 1'b1, 7'd9,  40'h6000,  2'd3, 1'b0, 40'h0,     2'd0, 1'b1, 7'd9,  1'b1, 8'd7},  // R7
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b1, 40'h5000,  2'd3, 1'b1, 7'd9,  1'b1, 8'd7},  // R7
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b1, 40'h6000,  2'd0, 1'b1, 7'd9,  1'b0, 8'd7},  // R7
        '{1'b0, 1'b1, 7'd1,  40'h100,   2'd3, 1'b0, 40'h0,     2'd0, 1'b0, 7'd0,  1'b0, 8'd8},  // R8
        '{1'b0, 1'b1, 7'd17, 40'h200,   2'd3, 1'b0, 40'h0,     2'd0, 1'b0, 7'd0,  1'b0, 8'd8},  // R8
        '{1'b0, 1'b1, 7'd33, 40'h300,   2'd3, 1'b0, 40'h0,     2'd0, 1'b0, 7'd0,  1'b0, 8'd8},  // R8
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd1,  1'b0, 8'd8},  // R8
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd17, 1'b1, 8'd8},  // R8
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd33, 1'b1, 8'd8},  // R8
        '{1'b0, 1'b1, 7'd17, 40'h210,   2'd3, 1'b0, 40'h0,     2'd0, 1'b0, 7'd0,  1'b0, 8'd8},  // R8
        '{1'b0, 1'b1, 7'd49, 40'h400,   2'd3, 1'b0, 40'h0,     2'd0, 1'b0, 7'd0,  1'b0, 8'd8},  // R8
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd33, 1'b0, 8'd8},  // R8
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd17, 1'b1, 8'd8},  // R8
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd49, 1'b1, 8'd8},  // R8
        '{1'b0, 1'b1, 7'd2,  40'h700,   2'd3, 1'b0, 40'h0,     2'd0, 1'b0, 7'd0,  1'b0, 8'd9},  // R9
        '{1'b0, 1'b1, 7'd18, 40'h800,   2'd3, 1'b0, 40'h0,     2'd0, 1'b0, 7'd0,  1'b0, 8'd9},  // R9
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b1, 40'h800,   2'd3, 1'b1, 7'd18, 1'b0, 8'd9},  // R9
        '{1'b0, 1'b1, 7'd34, 40'h900,   2'd3, 1'b0, 40'h0,     2'd0, 1'b0, 7'd0,  1'b0, 8'd9},  // R9
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd2,  1'b1, 8'd9},  // R9
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd34, 1'b1, 8'd9},  // R9
        '{1'b1, 1'b1, 7'd10, 40'hA00,   2'd3, 1'b0, 40'h0,     2'd0, 1'b1, 7'd2,  1'b0, 8'd11}, // R11
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd34, 1'b0, 8'd11}, // R11
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd10, 1'b0, 8'd11}, // R11
        '{1'b0, 1'b1, 7'd11, 40'hB00,   2'd3, 1'b1, 40'hB00,   2'd3, 1'b0, 7'd0,  1'b0, 8'd12}, // R12
        '{1'b0, 1'b0, 7'd0,  40'h0,     2'd0, 1'b0, 40'h0,     2'd0, 1'b1, 7'd11, 1'b1, 8'd12}  // R12
    };

    task automatic idle_inputs();
        ld_en = 1'b0; ld_reg = '0; ld_addr = '0; ld_size = '0;
        st_en = 1'b0; st_addr = '0; st_size = '0;
        chk_en = 1'b0; chk_reg = '0; inval_all = 1'b0;
    endtask

    task automatic check(input logic got, input logic exp, input int rq, input int idx);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d step %0d: chk_hit=%0b expected %0b", rq, idx, got, exp);
        end
    endtask

    // Drive at the falling edge, sample 2 ns later, commit at the next rising edge.
    task automatic apply(input vec_t v, input int idx);
        @(negedge clk);
        inval_all = v.clr;
        ld_en = v.a_v; ld_reg = v.a_reg; ld_addr = v.a_addr; ld_size = v.a_sz;
        st_en = v.s_v; st_addr = v.s_addr; st_size = v.s_sz;
        chk_en = v.c_v; chk_reg = v.c_reg;
        #2;
        if (v.c_v) check(chk_hit, v.exp, int'(v.rq), idx);
    endtask

    task automatic query(input int r, input logic exp, input int rq, input int idx);
        @(negedge clk);
        idle_inputs();
        chk_en = 1'b1; chk_reg = REG_W'(r);
        #2;
        check(chk_hit, exp, rq, idx);
    endtask

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) apply(VECS[i], i);

        // Fill every record (regs 0..31 cover both ways of all sets): R2, R9
        for (int r = 0; r < 32; r++) begin
            @(negedge clk);
            idle_inputs();
            ld_en = 1'b1; ld_reg = REG_W'(r);
            ld_addr = 40'h10000 + 40'(r * 8); ld_size = 2'd3;
        end
        for (int r = 0; r < 32; r++) query(r, 1'b1, 2, 100 + r);

        // One byte store on reg 20's block removes only that record: R4, R5
        @(negedge clk);
        idle_inputs();
        st_en = 1'b1; st_addr = 40'h10000 + 40'(20 * 8) + 40'd5; st_size = 2'd0;
        query(20, 1'b0, 4, 200);
        query(4, 1'b1, 5, 201);
        query(21, 1'b1, 5, 202);

        // Reset in the middle of operation empties the table: R1
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        query(4, 1'b0, 1, 300);
        query(31, 1'b0, 1, 301);

        @(negedge clk);
        idle_inputs();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule